// File: doc/BRIEF.md
# Scrolling Message Display Controller

This block drives a six-digit multiplexed seven-segment display with a seven-slot text ring: the letters H, E, L, L, O followed by two blank slots. Six digits act as a window onto the ring. On every step tick the whole window moves one slot, so the word travels across the display and wraps around through the blanks.

Two active-low push buttons control the motion. Each press of the speed button selects the next of four step periods (1 s, 0.4 s, 0.1 s, 0.02 s) and wraps back to the slowest. A press of the reverse button starts a five-second one-shot. During the one-shot the text travels left to right at a fixed 0.5 s step. When the interval ends, normal right-to-left motion resumes from wherever the text stands. Both buttons pass through a two-flop synchronizer and a press detector, so a held button counts once. A clock-frequency parameter scales every time constant, and a separate parameter sets the digit scan interval (200 clocks by default).

Top module: `hello_scroll`

## Requirements
- R1: During reset (rst_n low, sampled on the clock), the digit select is 6'b111110 (rightmost digit), the ring offset is zero, and the step period is the 1 s setting. After release the display shows, from left digit to right digit: blank, H, E, L, L, O.
- R2: The segment codes are: H = 8'h6E, E = 8'h9E, L = 8'h1C, O = 8'hFC, blank = 8'h00. Ring slots are numbered 0..6 as H, E, L, L, O, blank, blank. Digit d (0 = rightmost, active when dig_sel_n[d] is 0) shows slot (offset + 4 - d) mod 7.
- R3: In forward mode the offset increases by one (6 wraps to 0) once per step period, so the text moves right to left. The offset is always in 0..6.
- R4: The four speed settings, in press order starting from reset, give step periods of CLK_HZ, CLK_HZ*2/5, CLK_HZ/10 and CLK_HZ/50 clocks. A press on the last setting returns to the first.
- R5: A button counts as pressed while its input is low. The block sees one press event for each high-to-low transition, however long the button is held. The press takes effect three clock edges after the input falls (two synchronizer stages, then the event register update).
- R6: A reverse press starts a window of 5*CLK_HZ clocks. During the window the offset decreases by one (0 wraps to 6) every CLK_HZ/2 clocks. After the window, forward motion resumes from the current offset at the selected speed.
- R7: A reverse press during an active window restarts the full window without changing direction or offset.
- R8: When the direction changes, the step counter is cleared. The first step in the new direction therefore comes one full period after the change. A speed change does not clear the counter.
- R9: Exactly one digit select bit is low at a time. The select rotates left by one position (111110, then 111101, and so on) every SCAN_CLKS clocks, and seg always shows the glyph for the selected digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Synchronous reset, active low |
| spd_btn_n | input | 1 | Speed button, low while pressed, asynchronous |
| rev_btn_n | input | 1 | Reverse button, low while pressed, asynchronous |
| seg | output | 8 | Segment pattern for the selected digit, bit 7 first segment |
| dig_sel_n | output | 6 | Digit select, one-cold, bit 0 is the rightmost digit |

## Verification
The assertions take for granted two things about the inputs: reset is held low from time zero until at least one clock edge has passed, and the button inputs are clean levels, since debouncing happens off chip. Each button may change at any time relative to the clock. The bench changes buttons only on the falling clock edge. Every press is held for several clocks, from a few up to hundreds, so that the single-event rule for long holds is exercised. A simultaneous press of both buttons is included to show that the two buttons act independently.

// File: rtl/hello_scroll_pkg.sv
// Package: shared constants and glyph helpers for the scrolling display.
// Assumes a fixed seven-slot text ring viewed through six digits.
package hello_scroll_pkg;

    localparam int unsigned NUM_DIGITS = 6;
    localparam int unsigned RING_SLOTS = 7;
    localparam int unsigned SLOT_W     = 3;
    localparam int unsigned SEG_W      = 8;
    // Slot shown on the rightmost digit when the offset is zero (the O).
    localparam int unsigned ANCHOR     = 4;

    // Map a ring slot to its segment pattern.
    function automatic logic [SEG_W-1:0] slot_glyph(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd0:    return 8'h6E;
            3'd1:    return 8'h9E;
            3'd2,
            3'd3:    return 8'h1C;
            3'd4:    return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    // Ring slot visible on a digit for a given ring offset.
    function automatic logic [SLOT_W-1:0] digit_slot(input logic [SLOT_W-1:0] ofs,
                                                     input logic [SLOT_W-1:0] dig);
        int unsigned t;
        t = int'(ofs) + RING_SLOTS + ANCHOR - int'(dig);
        return SLOT_W'(t % RING_SLOTS);
    endfunction

endpackage

// File: rtl/hs_btn_edge.sv
// Module: button synchronizer and press detector.
// Assumes an active-low, already debounced button. Emits a one-cycle
// pulse for each transition from released to pressed.
module hs_btn_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);
    logic sync1, sync2, held;

    // Two-flop synchronizer on the pressed level, plus a delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            held  <= 1'b0;
        end else begin
            sync1 <= ~btn_n;
            sync2 <= sync1;
            held  <= sync2;
        end
    end

    // Pulse on the first synchronized cycle of a press.
    assign press = sync2 & ~held;

endmodule

// File: rtl/hs_step_ctrl.sv
// Module: speed selector, reverse one-shot, step tick and ring offset.
// Assumes press inputs are single-cycle pulses. All periods scale with CLK_HZ.
module hs_step_ctrl #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spd_evt,
    input  logic       rev_evt,
    output logic [2:0] ofs,
    output logic       rev_on
);
    localparam int unsigned STEP_S0  = CLK_HZ;
    localparam int unsigned STEP_S1  = (CLK_HZ * 2) / 5;
    localparam int unsigned STEP_S2  = CLK_HZ / 10;
    localparam int unsigned STEP_S3  = CLK_HZ / 50;
    localparam int unsigned STEP_REV = CLK_HZ / 2;
    localparam int unsigned REV_CLKS = 5 * CLK_HZ;
    localparam int unsigned CW       = $clog2(CLK_HZ + 1);
    localparam int unsigned RW       = $clog2(REV_CLKS + 1);
    localparam int unsigned LAST_OFS = hello_scroll_pkg::RING_SLOTS - 1;

    logic [1:0]    spd;
    logic [RW-1:0] rev_left;
    logic [CW-1:0] cnt, per;
    logic          rev_last, dir_chg, step;

    // Speed index: advance on each press, wrap after the fastest.
    always_ff @(posedge clk) begin
        if (!rst_n)       spd <= 2'd0;
        else if (spd_evt) spd <= spd + 2'd1;
    end

    // Reverse one-shot: load on press, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              rev_left <= '0;
        else if (rev_evt)        rev_left <= RW'(REV_CLKS);
        else if (rev_left != '0) rev_left <= rev_left - 1'b1;
    end

    assign rev_on   = (rev_left != '0);
    assign rev_last = (rev_left == RW'(1));
    assign dir_chg  = (rev_evt & ~rev_on) | (rev_last & ~rev_evt);

    // Active step period for the current direction and speed.
    always_comb begin
        case (spd)
            2'd0:    per = CW'(STEP_S0);
            2'd1:    per = CW'(STEP_S1);
            2'd2:    per = CW'(STEP_S2);
            default: per = CW'(STEP_S3);
        endcase
        if (rev_on) per = CW'(STEP_REV);
    end

    assign step = ~dir_chg & (cnt >= per - 1'b1);

    // Step counter: cleared on wrap and on a direction change.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (dir_chg || step)       cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    // Ring offset: one slot per step, in the active direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
        end else if (step) begin
            if (rev_on) ofs <= (ofs == '0) ? 3'(LAST_OFS) : ofs - 3'd1;
            else        ofs <= (ofs == 3'(LAST_OFS)) ? '0 : ofs + 3'd1;
        end
    end

endmodule

// File: rtl/hs_scan_drv.sv
// Module: digit scanner and character encoder.
// Assumes SCAN_CLKS >= 1. Select is one-cold; segments are combinational.
module hs_scan_drv #(
    parameter int unsigned SCAN_CLKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ofs,
    output logic [7:0] seg,
    output logic [5:0] sel_n
);
    import hello_scroll_pkg::*;

    localparam int unsigned DW = (SCAN_CLKS > 1) ? $clog2(SCAN_CLKS) : 1;

    logic [DW-1:0] div;
    logic [2:0]    dig;

    // Scan divider and active digit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div <= '0;
            dig <= '0;
        end else if (div == DW'(SCAN_CLKS - 1)) begin
            div <= '0;
            dig <= (dig == 3'(NUM_DIGITS - 1)) ? '0 : dig + 3'd1;
        end else begin
            div <= div + 1'b1;
        end
    end

    // One-cold select decode, one bit per digit.
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
        assign sel_n[i] = (dig != 3'(i));
    end

    // Glyph of the slot visible on the active digit.
    assign seg = slot_glyph(digit_slot(ofs, dig));

endmodule

// File: rtl/hello_scroll.sv
// Module: top of the scrolling message display controller.
// Assumes clean active-low buttons and a synchronous active-low reset.
module hello_scroll #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SCAN_CLKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spd_btn_n,
    input  logic       rev_btn_n,
    output logic [7:0] seg,
    output logic [5:0] dig_sel_n
);
    logic       spd_evt, rev_evt, rev_on;
    logic [2:0] ofs;

    hs_btn_edge u_spd_btn (.clk(clk), .rst_n(rst_n), .btn_n(spd_btn_n), .press(spd_evt));
    hs_btn_edge u_rev_btn (.clk(clk), .rst_n(rst_n), .btn_n(rev_btn_n), .press(rev_evt));

    hs_step_ctrl #(.CLK_HZ(CLK_HZ)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .spd_evt(spd_evt), .rev_evt(rev_evt),
        .ofs(ofs), .rev_on(rev_on)
    );

    hs_scan_drv #(.SCAN_CLKS(SCAN_CLKS)) u_scan (
        .clk(clk), .rst_n(rst_n), .ofs(ofs), .seg(seg), .sel_n(dig_sel_n)
    );

endmodule

// File: rtl/hello_scroll_chk.sv
// Checker: temporal properties of the display controller, bound to the top.
module hello_scroll_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] seg,
    input logic [5:0] sel_n,
    input logic       spd_evt,
    input logic       rev_evt,
    input logic [2:0] ofs,
    input logic       rev_on
);
    AST_SEL_ONECOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) == 1);                                               // R9
    AST_SEL_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_n) |-> sel_n == {$past(sel_n[4:0]), $past(sel_n[5])});     // R9
    AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        seg inside {8'h6E, 8'h9E, 8'h1C, 8'hFC, 8'h00});                       // R2
    AST_SPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        spd_evt |=> !spd_evt);                                                  // R5
    AST_REV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rev_evt |=> !rev_evt);                                                  // R5
    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ofs < 3'd7);                                                            // R3
    AST_OFS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ofs) && !$past(rev_on)) |->
        ofs == (($past(ofs) == 3'd6) ? 3'd0 : $past(ofs) + 3'd1));             // R3
    AST_OFS_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ofs) && $past(rev_on)) |->
        ofs == (($past(ofs) == 3'd0) ? 3'd6 : $past(ofs) - 3'd1));             // R6
    AST_REV_START: assert property (@(posedge clk) disable iff (!rst_n)
        rev_evt |=> rev_on);                                                    // R7
endmodule

bind hello_scroll hello_scroll_chk u_chk (
    .clk(clk), .rst_n(rst_n), .seg(seg), .sel_n(dig_sel_n),
    .spd_evt(spd_evt), .rev_evt(rev_evt), .ofs(ofs), .rev_on(rev_on)
);

// File: tb/hello_scroll_tb.sv
module hello_scroll_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HZ         = 1000;
    localparam int SCAN       = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spd_btn_n = 1'b1;
    logic       rev_btn_n = 1'b1;
    logic [7:0] seg;
    logic [5:0] dig_sel_n;

    hello_scroll #(.CLK_HZ(HZ), .SCAN_CLKS(SCAN)) u_dut (
        .clk(clk), .rst_n(rst_n), .spd_btn_n(spd_btn_n), .rev_btn_n(rev_btn_n),
        .seg(seg), .dig_sel_n(dig_sel_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    bit    armed = 0;
    bit    done  = 0;
    string cur_req = "R1";
    string text = "HELLO  ";

    // Behavioural reference state
    int m_hist_s[$];
    int m_hist_r[$];
    int m_spd, m_rev_left, m_cnt, m_ofs, m_tick, m_dig;

    function automatic int period_of(int sp);
        case (sp)
            0: return HZ;
            1: return HZ * 2 / 5;
            2: return HZ / 10;
            default: return HZ / 50;
        endcase
    endfunction

    function automatic logic [7:0] glyph(byte ch);
        case (ch)
            "H": return 8'h6E;
            "E": return 8'h9E;
            "L": return 8'h1C;
            "O": return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] expect_seg(int ofs, int d);
        return glyph(text[(ofs + 11 - d) % 7]);
    endfunction

    // A press is seen when the level two clocks back is pressed and three clocks back is not.
    function automatic bit edge_seen(ref int h[$]);
        return h.size() >= 3 && h[h.size()-2] == 1 && h[h.size()-3] == 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist_s = {0, 0, 0};
            m_hist_r = {0, 0, 0};
            m_spd = 0; m_rev_left = 0; m_cnt = 0; m_ofs = 0; m_tick = 0; m_dig = 0;
        end else begin
            bit sp, rp, on, chg, stp;
            int per;
            sp  = edge_seen(m_hist_s);
            rp  = edge_seen(m_hist_r);
            on  = m_rev_left > 0;
            chg = (rp && !on) || (m_rev_left == 1 && !rp);
            per = on ? HZ / 2 : period_of(m_spd);
            stp = !chg && (m_cnt >= per - 1);
            if (sp) m_spd = (m_spd + 1) % 4;
            if (rp) m_rev_left = 5 * HZ;
            else if (m_rev_left > 0) m_rev_left--;
            m_cnt = (chg || stp) ? 0 : m_cnt + 1;
            if (stp) m_ofs = on ? (m_ofs + 6) % 7 : (m_ofs + 1) % 7;
            if (m_tick == SCAN - 1) begin m_tick = 0; m_dig = (m_dig + 1) % 6; end
            else m_tick++;
            m_hist_s.push_back(!spd_btn_n);
            m_hist_r.push_back(!rev_btn_n);
            if (m_hist_s.size() > 3) void'(m_hist_s.pop_front());
            if (m_hist_r.size() > 3) void'(m_hist_r.pop_front());
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [5:0] es;
            logic [7:0] eg;
            es = ~(6'b1 << m_dig);
            eg = expect_seg(m_ofs, m_dig);
            tests++;
            if (dig_sel_n !== es || seg !== eg) begin
                fails++;
                if (fails < 12)
                    $display("FAIL %s cycle compare: sel=%b seg=%h expected sel=%b seg=%h",
                             cur_req, dig_sel_n, seg, es, eg);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_spd(int hold);
        spd_btn_n = 1'b0; cyc(hold); spd_btn_n = 1'b1; cyc(4);
    endtask

    task automatic push_rev(int hold);
        rev_btn_n = 1'b0; cyc(hold); rev_btn_n = 1'b1; cyc(4);
    endtask

    // Sweep all digits and compare each to the text at a known offset
    task automatic read_window(string req, int ofs);
        logic [7:0] win [6];
        for (int k = 0; k < 6 * SCAN; k++) begin
            @(negedge clk);
            for (int d = 0; d < 6; d++)
                if (dig_sel_n[d] == 1'b0) win[d] = seg;
        end
        for (int d = 0; d < 6; d++)
            check(req, $sformatf("digit %0d glyph", d), win[d], expect_seg(ofs, d));
    endtask

    initial begin
        cyc(5);
        check("R1", "select in reset", dig_sel_n, 6'b111110);
        check("R1", "segments in reset", seg, 8'hFC);
        rst_n = 1'b1;
        armed = 1'b1;
        cyc(SCAN);
        check("R9", "select after one scan interval", dig_sel_n, 6'b111101);
        read_window("R1", 0);               // blank H E L L O
        cyc(1200 - SCAN - 6 * SCAN);
        read_window("R3", 1);               // one step taken at 1000 clocks
        cur_req = "R3"; cyc(2000);
        cur_req = "R5"; push_spd(300); cyc(1500);
        cur_req = "R4"; push_spd(3); cyc(500);
        push_spd(3); cyc(200);
        push_spd(3); cyc(2200);
        cur_req = "R6"; push_rev(5); cyc(3000);
        cur_req = "R7"; push_rev(6); cyc(6000);
        cur_req = "R8"; push_spd(3); push_rev(3); cyc(5200);
        cur_req = "R2"; spd_btn_n = 1'b0; rev_btn_n = 1'b0; cyc(10);
        spd_btn_n = 1'b1; rev_btn_n = 1'b1; cyc(6000);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule